// File: doc/BRIEF.md
# Trap Context Shift Stack

This block keeps the trap context of a processor core in an on-chip stack built as a shift register, so that interrupts, exceptions and upcalls never have to save state to memory. When an event is taken, the program counter of the interrupted instruction and the current status word are pushed together as one entry. When the handler returns, the top entry is popped and the program counter, status flags and privilege level are restored in a single cycle. The privilege level is the low field of the status word, so every saved entry records the level the core was running at when the event arrived.

The block also chooses the privilege level that each event enters. There are four levels: application (0), guest OS (1), hypervisor (2) and secure monitor (3). Every trap (interrupt or exception) enters the secure monitor. The secure monitor can then hand the event down to a lower level with a delegate operation. An upcall moves exactly one level up. An upcall issued at the secure monitor level is illegal, and the block turns it into a trap with its own cause code. The top stack entry can be read and written through a control-register port. The far end of the stack is a fixed reset entry: a return with nothing on the stack causes a reset.

Traps arrive on a valid/ready interface. `trap_ready` is low only during the single cycle in which `core_reset` is high. While `trap_valid` is high and `trap_ready` is low, the trap is not taken and must be held until `trap_ready` returns. The upcall, return, delegate and control-register strobes are plain single-cycle requests and are never back-pressured.

Top module: `trap_ctx_stack`

## Requirements
- R1: After reset, the outputs are as follows: `fetch_pc` = RESET_PC (default 0x0100), `cur_mode` = 3, `cur_status` = 0x03, `cause` = 0, `depth` = 0, `overflow` = 0, `core_reset` = 0 and `trap_ready` = 1.
- R2: An accepted trap (`trap_valid` and `trap_ready` both high) has the following effects from the next cycle:
  - the entry {`exec_pc`, status word} is pushed;
  - `cur_mode` becomes 3;
  - `fetch_pc` takes `handler_pc`;
  - `cause` takes `trap_cause`;
  - the status flag bits clear;
  - `depth` rises by one.
- R3: An upcall at level 0, 1 or 2, with no trap in the same cycle, pushes the entry as R2 does, raises `cur_mode` by exactly one, loads `handler_pc`, clears the flags and sets `cause` to UPCALL_CAUSE (default 0x3E).
- R4: An upcall at level 3 pushes the entry, keeps `cur_mode` at 3, loads `handler_pc` and sets `cause` to BADCALL_CAUSE (default 0x3F).
- R5: A return with a non-empty stack pops the top entry and restores the following from it:
  - `fetch_pc` from the stacked PC;
  - the flags from status bits [7:2];
  - `cur_mode` as the lower of the stacked mode and the mode that executed the return.
- R6: A return with an empty stack raises `core_reset` for exactly one cycle and puts the block back in the R1 state. During that cycle `trap_ready` is 0 and every request is ignored.
- R7: A push onto a stack that already holds DEPTH (default 8) entries discards the oldest entry and keeps `depth` at DEPTH. It also sets `overflow`, which stays set until the next R6 reset.
- R8: A delegate at level 3 whose target `deleg_mode` is below 3 sets `cur_mode` to the target and `fetch_pc` to `handler_pc`, and leaves the stack and flags unchanged. A delegate at any other level, or with target 3, has no effect.
- R9: `csr_rdata` shows the top entry as {PC[23:8], status[7:0]}. When the stack is empty it shows the fixed entry {RESET_PC, 0x03}. `csr_we` replaces the top entry with `csr_wdata` only at level 3 with a non-empty stack; otherwise it is ignored.
- R10: When several requests are raised in the same cycle, exactly one acts, in this order of priority: trap, upcall, return, delegate, control-register write. The others are dropped.
- R11: Bits [1:0] of the status word in a pushed entry hold the privilege level that was current when the event was taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| trap_valid | input | 1 | Trap request valid |
| trap_ready | output | 1 | Trap can be accepted this cycle |
| trap_cause | input | 6 | Cause code of the trap |
| exec_pc | input | 16 | PC of the interrupted instruction, saved on push |
| handler_pc | input | 16 | Target PC for a trap, upcall or delegate |
| upcall_req | input | 1 | Upcall strobe |
| ret_req | input | 1 | Return strobe |
| deleg_req | input | 1 | Delegate strobe |
| deleg_mode | input | 2 | Target level of a delegate |
| csr_we | input | 1 | Write strobe for the top entry |
| csr_wdata | input | 24 | Data written to the top entry |
| csr_rdata | output | 24 | Top entry read value |
| fetch_pc | output | 16 | Current program counter |
| cur_mode | output | 2 | Current privilege level |
| cur_status | output | 8 | Current status word (flags[7:2], mode[1:0]) |
| cause | output | 6 | Cause of the last event taken |
| depth | output | 4 | Number of valid stack entries |
| overflow | output | 1 | Sticky flag: an entry was lost to overflow |
| core_reset | output | 1 | One-cycle reset pulse on stack underflow |

## Verification
A stack entry that shifts the wrong way, or a corrupted valid bit, shows up on `csr_rdata` and `depth` in the very next cycle. It shows up again when later returns restore `fetch_pc` and `cur_mode`, at a point that depends on how deep the error is buried. A wrong level decision (upcall step, delegate gate or return clamp) shows on `cur_mode` one cycle after the request. A lost or extra valid bit at the far end changes the return on which `core_reset` fires, which can be many cycles after the original fault. The bench therefore compares every output on every cycle against a model, so that a fault is reported on the cycle it first becomes visible.

// File: rtl/trap_ctx_pkg.sv
package trap_ctx_pkg;

  localparam int unsigned LVL_W = 2;

  typedef enum logic [LVL_W-1:0] {
    LVL_APP    = 2'd0,
    LVL_GUEST  = 2'd1,
    LVL_HYP    = 2'd2,
    LVL_SECURE = 2'd3
  } priv_lvl_e;

  typedef enum logic [2:0] {
    OP_IDLE,
    OP_TRAP,
    OP_UPCALL,
    OP_BADCALL,
    OP_RETURN,
    OP_UNDERFLOW,
    OP_DELEGATE,
    OP_CSRWR
  } ctx_op_e;

  function automatic priv_lvl_e lower_of(priv_lvl_e a, priv_lvl_e b);
    return (a < b) ? a : b;
  endfunction

endpackage

// File: rtl/trap_ctx_shift_store.sv
module trap_ctx_shift_store #(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned EW    = 24,
  parameter logic [EW-1:0] FLOOR = '0,
  localparam int unsigned DW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          push,
  input  logic          pop,
  input  logic          wr_top,
  input  logic [EW-1:0] push_data,
  input  logic [EW-1:0] wr_data,
  output logic [EW-1:0] top_data,
  output logic          top_valid,
  output logic          full,
  output logic [DW-1:0] count
);

  logic [EW-1:0] slot     [DEPTH];
  logic          vld      [DEPTH];
  // Value each slot takes on a push (from the slot above it) or a pop (from the slot below it).
  logic [EW-1:0] from_up  [DEPTH];
  logic          vup      [DEPTH];
  logic [EW-1:0] from_dn  [DEPTH];
  logic          vdn      [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    if (i == 0) begin : g_head
      assign from_up[i] = push_data;
      assign vup[i]     = 1'b1;
    end else begin : g_body
      assign from_up[i] = slot[i-1];
      assign vup[i]     = vld[i-1];
    end
    if (i == DEPTH - 1) begin : g_floor
      // The far end is hard-wired: a pop shifts the fixed reset entry in.
      assign from_dn[i] = FLOOR;
      assign vdn[i]     = 1'b0;
    end else begin : g_inner
      assign from_dn[i] = slot[i+1];
      assign vdn[i]     = vld[i+1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        slot[i] <= FLOOR;
        vld[i]  <= 1'b0;
      end else if (clear) begin
        slot[i] <= FLOOR;
        vld[i]  <= 1'b0;
      end else if (push) begin
        slot[i] <= from_up[i];
        vld[i]  <= vup[i];
      end else if (pop) begin
        slot[i] <= from_dn[i];
        vld[i]  <= vdn[i];
      end else if (wr_top && (i == 0) && vld[i]) begin
        slot[i] <= wr_data;
      end
    end
  end

  assign top_valid = vld[0];
  assign top_data  = vld[0] ? slot[0] : FLOOR;
  assign full      = vld[DEPTH-1];

  always_comb begin
    count = '0;
    for (int k = 0; k < DEPTH; k++) begin
      count = count + DW'(vld[k]);
    end
  end

endmodule

// File: rtl/trap_ctx_arbiter.sv
module trap_ctx_arbiter
  import trap_ctx_pkg::*;
(
  input  logic      hold,
  input  logic      trap_valid,
  input  logic      upcall_req,
  input  logic      ret_req,
  input  logic      deleg_req,
  input  priv_lvl_e deleg_lvl,
  input  logic      csr_we,
  input  priv_lvl_e cur_lvl,
  input  priv_lvl_e top_lvl,
  input  logic      top_valid,
  output ctx_op_e   op,
  output priv_lvl_e next_lvl,
  output logic      push,
  output logic      pop,
  output logic      wr_top,
  output logic      wipe
);

  logic [LVL_W-1:0] step_up;
  assign step_up = cur_lvl + 2'd1;

  always_comb begin
    op       = OP_IDLE;
    next_lvl = cur_lvl;
    push     = 1'b0;
    pop      = 1'b0;
    wr_top   = 1'b0;
    wipe     = 1'b0;
    if (!hold) begin
      if (trap_valid) begin
        op       = OP_TRAP;
        next_lvl = LVL_SECURE;
        push     = 1'b1;
      end else if (upcall_req) begin
        push = 1'b1;
        if (cur_lvl == LVL_SECURE) begin
          op       = OP_BADCALL;
          next_lvl = LVL_SECURE;
        end else begin
          op       = OP_UPCALL;
          next_lvl = priv_lvl_e'(step_up);
        end
      end else if (ret_req) begin
        if (top_valid) begin
          op       = OP_RETURN;
          pop      = 1'b1;
          next_lvl = lower_of(top_lvl, cur_lvl);
        end else begin
          op       = OP_UNDERFLOW;
          wipe     = 1'b1;
          next_lvl = LVL_SECURE;
        end
      end else if (deleg_req) begin
        if ((cur_lvl == LVL_SECURE) && (deleg_lvl != LVL_SECURE)) begin
          op       = OP_DELEGATE;
          next_lvl = deleg_lvl;
        end
      end else if (csr_we) begin
        if ((cur_lvl == LVL_SECURE) && top_valid) begin
          op     = OP_CSRWR;
          wr_top = 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/trap_ctx_stack.sv
module trap_ctx_stack
  import trap_ctx_pkg::*;
#(
  parameter int unsigned PCW   = 16,
  parameter int unsigned DEPTH = 8,
  parameter int unsigned CW    = 6,
  parameter int unsigned FLAGW = 6,
  parameter logic [PCW-1:0] RESET_PC      = 16'h0100,
  parameter logic [CW-1:0]  UPCALL_CAUSE  = 6'h3E,
  parameter logic [CW-1:0]  BADCALL_CAUSE = 6'h3F,
  localparam int unsigned SRW = FLAGW + LVL_W,
  localparam int unsigned EW  = PCW + SRW,
  localparam int unsigned DW  = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             trap_valid,
  output logic             trap_ready,
  input  logic [CW-1:0]    trap_cause,
  input  logic [PCW-1:0]   exec_pc,
  input  logic [PCW-1:0]   handler_pc,
  input  logic             upcall_req,
  input  logic             ret_req,
  input  logic             deleg_req,
  input  logic [LVL_W-1:0] deleg_mode,
  input  logic             csr_we,
  input  logic [EW-1:0]    csr_wdata,
  output logic [EW-1:0]    csr_rdata,
  output logic [PCW-1:0]   fetch_pc,
  output logic [LVL_W-1:0] cur_mode,
  output logic [SRW-1:0]   cur_status,
  output logic [CW-1:0]    cause,
  output logic [DW-1:0]    depth,
  output logic             overflow,
  output logic             core_reset
);

  localparam logic [EW-1:0] FLOOR_ENTRY = {RESET_PC, {FLAGW{1'b0}}, LVL_SECURE};

  logic [PCW-1:0]   pc_q;
  priv_lvl_e        lvl_q;
  logic [FLAGW-1:0] flags_q;
  logic [CW-1:0]    cause_q;
  logic             ovf_q;
  logic             rstp_q;

  logic [EW-1:0]    top_entry;
  logic             top_valid;
  logic             stk_full;
  logic [DW-1:0]    stk_count;

  ctx_op_e          op;
  priv_lvl_e        next_lvl;
  logic             push;
  logic             pop;
  logic             wr_top;
  logic             wipe;

  logic [SRW-1:0]   sr_now;
  logic [PCW-1:0]   top_pc;
  logic [FLAGW-1:0] top_flags;
  priv_lvl_e        top_lvl;

  assign sr_now    = {flags_q, lvl_q};
  assign top_pc    = top_entry[EW-1 -: PCW];
  assign top_flags = top_entry[SRW-1 -: FLAGW];
  assign top_lvl   = priv_lvl_e'(top_entry[LVL_W-1:0]);

  trap_ctx_arbiter u_arb (
    .hold       (rstp_q),
    .trap_valid (trap_valid),
    .upcall_req (upcall_req),
    .ret_req    (ret_req),
    .deleg_req  (deleg_req),
    .deleg_lvl  (priv_lvl_e'(deleg_mode)),
    .csr_we     (csr_we),
    .cur_lvl    (lvl_q),
    .top_lvl    (top_lvl),
    .top_valid  (top_valid),
    .op         (op),
    .next_lvl   (next_lvl),
    .push       (push),
    .pop        (pop),
    .wr_top     (wr_top),
    .wipe       (wipe)
  );

  trap_ctx_shift_store #(
    .DEPTH (DEPTH),
    .EW    (EW),
    .FLOOR (FLOOR_ENTRY)
  ) u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear     (wipe),
    .push      (push),
    .pop       (pop),
    .wr_top    (wr_top),
    .push_data ({exec_pc, sr_now}),
    .wr_data   (csr_wdata),
    .top_data  (top_entry),
    .top_valid (top_valid),
    .full      (stk_full),
    .count     (stk_count)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q    <= RESET_PC;
      lvl_q   <= LVL_SECURE;
      flags_q <= '0;
      cause_q <= '0;
      ovf_q   <= 1'b0;
      rstp_q  <= 1'b0;
    end else begin
      rstp_q <= (op == OP_UNDERFLOW);
      lvl_q  <= next_lvl;
      case (op)
        OP_TRAP: begin
          pc_q    <= handler_pc;
          flags_q <= '0;
          cause_q <= trap_cause;
        end
        OP_UPCALL: begin
          pc_q    <= handler_pc;
          flags_q <= '0;
          cause_q <= UPCALL_CAUSE;
        end
        OP_BADCALL: begin
          pc_q    <= handler_pc;
          flags_q <= '0;
          cause_q <= BADCALL_CAUSE;
        end
        OP_RETURN: begin
          pc_q    <= top_pc;
          flags_q <= top_flags;
        end
        OP_UNDERFLOW: begin
          pc_q    <= RESET_PC;
          flags_q <= '0;
          cause_q <= '0;
          ovf_q   <= 1'b0;
        end
        OP_DELEGATE: begin
          pc_q <= handler_pc;
        end
        default: begin
        end
      endcase
      if (push && stk_full) begin
        ovf_q <= 1'b1;
      end
    end
  end

  assign trap_ready = !rstp_q;
  assign csr_rdata  = top_entry;
  assign fetch_pc   = pc_q;
  assign cur_mode   = lvl_q;
  assign cur_status = sr_now;
  assign cause      = cause_q;
  assign depth      = stk_count;
  assign overflow   = ovf_q;
  assign core_reset = rstp_q;

endmodule

// File: rtl/trap_ctx_stack_chk.sv
module trap_ctx_stack_chk #(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned DW    = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          trap_valid,
  input logic          trap_ready,
  input logic          upcall_req,
  input logic          ret_req,
  input logic          deleg_req,
  input logic [1:0]    cur_mode,
  input logic [DW-1:0] depth,
  input logic          overflow,
  input logic          core_reset
);

  // R6
  single_reset_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    core_reset |=> !core_reset);

  // R6
  reset_blocks_trap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    core_reset |-> !trap_ready);

  // R2
  trap_enters_secure_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_valid && trap_ready) |=> (cur_mode == 2'd3));

  // R7
  overflow_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |=> (overflow || core_reset));

  // R7
  depth_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    depth <= DW'(DEPTH));

  // R5
  return_no_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_ready && !trap_valid && !upcall_req && ret_req)
      |=> (core_reset || (cur_mode <= $past(cur_mode))));

  // R8
  low_delegate_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_ready && !trap_valid && !upcall_req && !ret_req && deleg_req && (cur_mode != 2'd3))
      |=> $stable(cur_mode));

endmodule

bind trap_ctx_stack trap_ctx_stack_chk #(.DEPTH(DEPTH), .DW(DW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .trap_valid (trap_valid),
  .trap_ready (trap_ready),
  .upcall_req (upcall_req),
  .ret_req    (ret_req),
  .deleg_req  (deleg_req),
  .cur_mode   (cur_mode),
  .depth      (depth),
  .overflow   (overflow),
  .core_reset (core_reset)
);

// File: tb/trap_ctx_stack_bench.sv
`timescale 1ns/1ps
module trap_ctx_stack_bench;

  localparam int PCW = 16;
  localparam int CW  = 6;
  localparam int SRW = 8;
  localparam int EW  = 24;
  localparam int DEP = 8;
  localparam logic [PCW-1:0] RST_PC = 16'h0100;
  localparam logic [CW-1:0]  UPC    = 6'h3E;
  localparam logic [CW-1:0]  BADC   = 6'h3F;
  localparam logic [EW-1:0]  FLOOR  = {RST_PC, 8'h03};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic trap_valid = 1'b0;
  logic trap_ready;
  logic [CW-1:0] trap_cause = '0;
  logic [PCW-1:0] exec_pc = '0;
  logic [PCW-1:0] handler_pc = '0;
  logic upcall_req = 1'b0;
  logic ret_req = 1'b0;
  logic deleg_req = 1'b0;
  logic [1:0] deleg_mode = '0;
  logic csr_we = 1'b0;
  logic [EW-1:0] csr_wdata = '0;
  logic [EW-1:0] csr_rdata;
  logic [PCW-1:0] fetch_pc;
  logic [1:0] cur_mode;
  logic [SRW-1:0] cur_status;
  logic [CW-1:0] cause;
  logic [3:0] depth;
  logic overflow;
  logic core_reset;

  always #2.5 clk = ~clk;

  trap_ctx_stack u_trap_ctx_stack (.*);

  int checks = 0;
  int errors = 0;

  logic [PCW-1:0] m_pc;
  logic [1:0]     m_lvl;
  logic [5:0]     m_flags;
  logic [CW-1:0]  m_cause;
  logic           m_ovf;
  logic           m_rst;
  int             m_cnt;
  logic [EW-1:0]  m_stk [DEP];
  logic [1:0]     m_prior;
  logic           m_pushed;

  function automatic logic [1:0] min_lvl(logic [1:0] a, logic [1:0] b);
    return (a < b) ? a : b;
  endfunction

  function automatic logic [EW-1:0] top_of();
    return (m_cnt > 0) ? m_stk[0] : FLOOR;
  endfunction

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic model_reset();
    m_pc = RST_PC; m_lvl = 2'd3; m_flags = '0; m_cause = '0;
    m_ovf = 1'b0; m_rst = 1'b0; m_cnt = 0;
    for (int i = 0; i < DEP; i++) m_stk[i] = FLOOR;
  endtask

  task automatic model_push(logic [EW-1:0] e, inout string tag);
    for (int i = DEP - 1; i > 0; i--) m_stk[i] = m_stk[i-1];
    m_stk[0] = e;
    if (m_cnt == DEP) begin m_ovf = 1'b1; tag = "R7"; end
    else m_cnt++;
    m_pushed = 1'b1;
  endtask

  task automatic compare_all(string tag);
    check(tag, "trap_ready", 32'(trap_ready), 32'(!m_rst));
    check(tag, "core_reset", 32'(core_reset), 32'(m_rst));
    check(tag, "fetch_pc", 32'(fetch_pc), 32'(m_pc));
    check(tag, "cur_mode", 32'(cur_mode), 32'(m_lvl));
    check(tag, "cur_status", 32'(cur_status), 32'({m_flags, m_lvl}));
    check(tag, "cause", 32'(cause), 32'(m_cause));
    check(tag, "depth", 32'(depth), 32'(m_cnt));
    check(tag, "overflow", 32'(overflow), 32'(m_ovf));
    check(tag, "csr_rdata", 32'(csr_rdata), 32'(top_of()));
  endtask

  task automatic step(bit tv, logic [CW-1:0] tc, logic [PCW-1:0] epc, logic [PCW-1:0] hpc,
                      bit up, bit rt, bit dg, logic [1:0] dm, bit we, logic [EW-1:0] wd);
    string tag;
    int nreq;
    trap_valid = tv; trap_cause = tc; exec_pc = epc; handler_pc = hpc;
    upcall_req = up; ret_req = rt; deleg_req = dg; deleg_mode = dm;
    csr_we = we; csr_wdata = wd;
    tag = "R10";
    m_pushed = 1'b0;
    m_prior = m_lvl;
    nreq = int'(tv) + int'(up) + int'(rt) + int'(dg) + int'(we);
    if (m_rst) begin
      m_rst = 1'b0; tag = "R6";
    end else if (tv) begin
      tag = "R2";
      model_push({epc, m_flags, m_lvl}, tag);
      m_lvl = 2'd3; m_pc = hpc; m_flags = '0; m_cause = tc;
    end else if (up) begin
      tag = (m_lvl == 2'd3) ? "R4" : "R3";
      model_push({epc, m_flags, m_lvl}, tag);
      if (m_lvl == 2'd3) m_cause = BADC;
      else begin m_cause = UPC; m_lvl = m_lvl + 2'd1; end
      m_pc = hpc; m_flags = '0;
    end else if (rt) begin
      if (m_cnt == 0) begin
        model_reset(); m_rst = 1'b1; tag = "R6";
      end else begin
        tag = "R5";
        m_pc = m_stk[0][EW-1 -: PCW];
        m_flags = m_stk[0][7:2];
        m_lvl = min_lvl(m_stk[0][1:0], m_lvl);
        for (int i = 0; i < DEP - 1; i++) m_stk[i] = m_stk[i+1];
        m_stk[DEP-1] = FLOOR;
        m_cnt--;
      end
    end else if (dg) begin
      tag = "R8";
      if (m_lvl == 2'd3 && dm != 2'd3) begin m_lvl = dm; m_pc = hpc; end
    end else if (we) begin
      tag = "R9";
      if (m_lvl == 2'd3 && m_cnt > 0) m_stk[0] = wd;
    end
    if (nreq > 1 && tag != "R6" && tag != "R7") tag = "R10";
    @(negedge clk);
    compare_all(tag);
    if (m_pushed) check("R11", "stacked mode", 32'(csr_rdata[1:0]), 32'(m_prior));
  endtask

  task automatic idle();
    step(0, '0, '0, '0, 0, 0, 0, 2'd0, 0, '0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd20250405));
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    compare_all("R1");

    // R6: return on empty stack resets; a trap during the pulse is ignored
    step(0, '0, '0, '0, 0, 1, 0, 2'd0, 0, '0);
    step(1, 6'h05, 16'h1111, 16'h2222, 0, 0, 0, 2'd0, 0, '0);
    idle();
    // R8: delegate down to application level, then R3 climbs and R11 marks prior level
    step(0, '0, '0, 16'h0400, 0, 0, 1, 2'd0, 0, '0);
    step(0, '0, 16'h0410, 16'h0500, 1, 0, 0, 2'd0, 0, '0);
    // R8: delegate below secure level is ignored
    step(0, '0, '0, 16'h0777, 0, 0, 1, 2'd0, 0, '0);
    // R9: write below secure level is ignored
    step(0, '0, '0, '0, 0, 0, 0, 2'd0, 1, 24'hABCDEF);
    step(0, '0, 16'h0510, 16'h0600, 1, 0, 0, 2'd0, 0, '0);
    step(0, '0, 16'h0610, 16'h0700, 1, 0, 0, 2'd0, 0, '0);
    // R4: upcall from secure level
    step(0, '0, 16'h0710, 16'h0800, 1, 0, 0, 2'd0, 0, '0);
    // R9: write at secure level lands on the top entry, then R5 restores flags
    step(0, '0, '0, '0, 0, 0, 0, 2'd0, 1, 24'h123456);
    step(0, '0, '0, '0, 0, 1, 0, 2'd0, 0, '0);
    // R10: all requests at once, trap wins
    step(1, 6'h09, 16'h0900, 16'h0A00, 1, 1, 1, 2'd1, 1, 24'h0);
    // R7: fill beyond depth
    for (int k = 0; k < DEP + 2; k++)
      step(1, 6'(k), 16'(16'h1000 + k), 16'(16'h2000 + k), 0, 0, 0, 2'd0, 0, '0);
    // drain past the bottom: R5 then R6
    for (int k = 0; k < DEP + 1; k++) step(0, '0, '0, '0, 0, 1, 0, 2'd0, 0, '0);
    idle();

    for (int n = 0; n < 3000; n++) begin
      step(($urandom % 100) < 15, 6'($urandom), 16'($urandom), 16'($urandom),
           ($urandom % 100) < 15, ($urandom % 100) < 32, ($urandom % 100) < 20,
           2'($urandom), ($urandom % 100) < 20, 24'($urandom));
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule